// File: doc/BRIEF.md
# Motorised Door Controller

This block is a synchronous Moore state machine that commands a motorised door. It takes a one-clock push-button pulse, two end-of-travel switches (fully raised, fully lowered) and a path-obstruction sensor. It produces three registered commands: drive upward, drive downward, and a fault flag that calls for repair.

Each button press in a resting position reverses the direction of travel. A press while the door rises stops it, and the next press lowers it. While the door descends, an obstruction stops it, and the next press always raises it. If both end switches read active at the same time, the sensors cannot be trusted. The machine then locks into a fault state that only reset clears. After reset the machine assumes the door is fully lowered.

Top module: `door_ctrl`

## Requirements
- R1: After reset (rst_ni low) the controller is in the lowered rest state, with open_o, close_o and halt_o all 0.
- R2: open_o is 1 only while the door rises, close_o only while it descends, and halt_o only in the fault state. open_o and close_o are never 1 together, and both are 0 in every resting or stopped state.
- R3: up_lim_i and down_lim_i both 1 on a clock edge sends the machine, from any state, to the fault state on that edge: halt_o=1, open_o=0, close_o=0.
- R4: Once in the fault state, the machine stays there whatever the inputs, until rst_ni asserts.
- R5: A btn_i pulse in the lowered rest state starts rising (open_o=1). A pulse in the raised rest state starts descending (close_o=1).
- R6: While rising, up_lim_i=1 moves the machine to the raised rest state, and takes priority over btn_i. blocked_i has no effect while rising.
- R7: While rising, btn_i=1 with up_lim_i=0 stops the door in the stopped-while-rising state (all outputs 0). A later btn_i pulse there starts descending.
- R8: While descending, down_lim_i=1 moves the machine to the lowered rest state, and takes priority over blocked_i and btn_i. blocked_i=1 with down_lim_i=0 moves it to the stopped-after-descent state (all outputs 0).
- R9: In either stopped state the machine holds while btn_i=0. In the stopped-after-descent state a btn_i pulse always starts rising.
- R10: While descending, btn_i=1 with blocked_i=0 and down_lim_i=0 also moves the machine to the stopped-after-descent state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_i | input | 1 | Remote button, one-clock pulse |
| up_lim_i | input | 1 | Door fully raised |
| down_lim_i | input | 1 | Door fully lowered |
| blocked_i | input | 1 | Obstruction in the door path |
| open_o | output | 1 | Drive door upward |
| close_o | output | 1 | Drive door downward |
| halt_o | output | 1 | Fault, repair needed |

## Verification
The block has no tunable parameters. The bench builds it as it stands, with its three-bit state encoding. Random stimulus keeps the two end switches rarely active together and applies reset from time to time. This lets long walks pass through all seven states, including both stopped states and repeated entries into and exits from the fault state. Directed steps cover the priority orderings: up switch over button, down switch over obstruction over button, and fault over everything.

// File: rtl/door_pkg.sv
package door_pkg;
  typedef enum logic [2:0] {
    ST_LOWERED  = 3'd0,
    ST_RISING   = 3'd1,
    ST_RAISED   = 3'd2,
    ST_FALLING  = 3'd3,
    ST_STOP_UP  = 3'd4,
    ST_STOP_DN  = 3'd5,
    ST_FAULT    = 3'd6
  } door_state_e;

  localparam int unsigned STATE_W = $bits(door_state_e);
endpackage

// File: rtl/door_next.sv
module door_next
  import door_pkg::*;
(
  input  door_state_e cur_i,
  input  logic        btn_i,
  input  logic        up_lim_i,
  input  logic        down_lim_i,
  input  logic        blocked_i,
  output door_state_e nxt_o
);
  logic sensor_clash;
  assign sensor_clash = up_lim_i & down_lim_i;

  always_comb begin
    nxt_o = cur_i;
    if (sensor_clash) begin
      nxt_o = ST_FAULT;
    end else begin
      unique case (cur_i)
        ST_LOWERED: if (btn_i) nxt_o = ST_RISING;
        ST_RISING: begin
          // obstruction deliberately not looked at while rising
          if (up_lim_i)   nxt_o = ST_RAISED;
          else if (btn_i) nxt_o = ST_STOP_UP;
        end
        ST_RAISED:  if (btn_i) nxt_o = ST_FALLING;
        ST_FALLING: begin
          if (down_lim_i)     nxt_o = ST_LOWERED;
          else if (blocked_i) nxt_o = ST_STOP_DN;
          else if (btn_i)     nxt_o = ST_STOP_DN;
        end
        ST_STOP_UP: if (btn_i) nxt_o = ST_FALLING;
        ST_STOP_DN: if (btn_i) nxt_o = ST_RISING;
        ST_FAULT:   nxt_o = ST_FAULT;
        default:    nxt_o = ST_FAULT;
      endcase
    end
  end
endmodule

// File: rtl/door_drive.sv
module door_drive
  import door_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  door_state_e cur_i,
  output logic        open_o,
  output logic        close_o,
  output logic        halt_o
);
  always_comb begin
    open_o  = 1'b0;
    close_o = 1'b0;
    halt_o  = 1'b0;
    unique case (cur_i)
      ST_RISING:  open_o  = 1'b1;
      ST_FALLING: close_o = 1'b1;
      ST_FAULT:   halt_o  = 1'b1;
      default: ;
    endcase
  end

  AST_ONE_DIRECTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(open_o && close_o)); // R2
  AST_HALT_STILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !open_o && !close_o); // R2
endmodule

// File: rtl/door_ctrl.sv
module door_ctrl
  import door_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_i,
  input  logic up_lim_i,
  input  logic down_lim_i,
  input  logic blocked_i,
  output logic open_o,
  output logic close_o,
  output logic halt_o
);
  door_state_e state_q, state_d;

  door_next u_next (
    .cur_i      (state_q),
    .btn_i      (btn_i),
    .up_lim_i   (up_lim_i),
    .down_lim_i (down_lim_i),
    .blocked_i  (blocked_i),
    .nxt_o      (state_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_LOWERED;
    else         state_q <= state_d;
  end

  door_drive u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cur_i   (state_q),
    .open_o  (open_o),
    .close_o (close_o),
    .halt_o  (halt_o)
  );

  AST_FAULT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_lim_i && down_lim_i) |=> halt_o); // R3
  AST_FAULT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o); // R4
  AST_PRESS_FROM_LOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOWERED && btn_i && !(up_lim_i && down_lim_i)) |=> open_o); // R5
  AST_RISE_IGNORES_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (open_o && !btn_i && !up_lim_i) |=> open_o); // R6
  AST_BLOCK_STOPS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (close_o && blocked_i && !down_lim_i && !up_lim_i) |=> !close_o && !open_o && !halt_o); // R8
endmodule

// File: tb/door_ctrl_bench.sv
`timescale 1ns/1ps
module door_ctrl_bench;
  localparam real CLK_NS  = 8.0;
  localparam int  WD_CYC  = 200000;
  localparam int  RND_CYC = 4000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic btn = 1'b0, up = 1'b0, dn = 1'b0, blk = 1'b0;
  logic open_o, close_o, halt_o;
  int total = 0, bad = 0;
  int mdl = 0;  // 0 low,1 rise,2 high,3 fall,4 stop_up,5 stop_dn,6 fault
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  door_ctrl u_door_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .btn_i(btn), .up_lim_i(up),
    .down_lim_i(dn), .blocked_i(blk),
    .open_o(open_o), .close_o(close_o), .halt_o(halt_o)
  );

  function automatic int ref_next(int s, bit p, bit u, bit d, bit b);
    if (u && d) return 6;
    case (s)
      0: return p ? 1 : 0;
      1: return u ? 2 : (p ? 4 : 1);
      2: return p ? 3 : 2;
      3: return d ? 0 : ((b || p) ? 5 : 3);
      4: return p ? 3 : 4;
      5: return p ? 1 : 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [2:0] ref_out(int s);
    return {s == 1, s == 3, s == 6};
  endfunction

  task automatic check(string tag);
    logic [2:0] exp, act;
    exp = ref_out(mdl);
    act = {open_o, close_o, halt_o};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s state=%0d actual open/close/halt=%b expected=%b", tag, mdl, act, exp);
    end
  endtask

  task automatic cyc(bit p, bit u, bit d, bit b, string tag);
    btn = p; up = u; dn = d; blk = b;
    @(posedge clk);
    mdl = ref_next(mdl, p, u, d, b);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset(string tag);
    btn = 0; up = 0; dn = 0; blk = 0;
    rst_ni = 1'b0;
    @(posedge clk);
    @(negedge clk);
    mdl = 0;
    check(tag);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_NS * WD_CYC);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset("R1");
    cyc(0,0,0,1, "R2 idle low");
    cyc(1,0,0,0, "R5 low->rise");
    cyc(0,0,0,1, "R6 block ignored rising");
    cyc(0,0,0,1, "R6 block ignored rising");
    cyc(1,0,0,0, "R7 press stops rise");
    cyc(0,0,0,0, "R9 stop_up holds");
    cyc(0,0,0,1, "R9 stop_up holds");
    cyc(1,0,0,0, "R7 press after stop -> fall");
    cyc(1,0,0,1, "R8 block stops fall");
    cyc(0,0,0,0, "R9 stop_dn holds");
    cyc(1,0,0,0, "R9 stop_dn press -> rise");
    cyc(1,1,0,0, "R6 up limit over press");
    cyc(0,0,0,0, "R2 idle high");
    cyc(1,0,0,0, "R5 high->fall");
    cyc(1,0,0,0, "R10 press while falling");
    cyc(1,0,0,0, "R9 stop_dn -> rise");
    cyc(0,1,0,0, "R6 reach top");
    cyc(1,0,0,0, "R5 high->fall");
    cyc(1,0,1,1, "R8 down limit wins");
    cyc(0,1,1,0, "R3 clash from rest");
    cyc(1,0,0,0, "R4 fault sticky");
    cyc(0,0,1,1, "R4 fault sticky");
    cyc(0,1,0,0, "R4 fault sticky");
    do_reset("R1 leave fault");
    cyc(1,0,0,0, "R5 low->rise");
    cyc(1,1,1,1, "R3 clash while rising");
    do_reset("R1");

    for (int i = 0; i < RND_CYC; i++) begin
      bit p, u, d, b;
      p = ($urandom_range(0, 3) == 0);
      b = ($urandom_range(0, 4) == 0);
      u = ($urandom_range(0, 7) == 0);
      d = ($urandom_range(0, 7) == 0);
      if (u && d && $urandom_range(0, 9) != 0) d = 0;
      if ($urandom_range(0, 149) == 0) do_reset("R1 random reset");
      else cyc(p, u, d, b, "R2 random walk");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule